// File: doc/BRIEF.md
# Prescaled Dual Timer with Watchdog

This block provides time bases for a processor subsystem. A single prescaler divides the system clock and produces a one-cycle tick every (prescaler reload + 1) clock cycles. Two general-purpose 24-bit down counters and one 24-bit watchdog counter advance only on that tick. Between ticks, none of the counters moves.

Each general-purpose timer runs either periodically or once. In periodic mode it reloads on underflow and continues. In one-shot mode it halts and clears its own enable bit. Every underflow raises a one-clock interrupt pulse on that timer's output. The watchdog drives an active-low timeout output when its count reaches zero. Software restarts the watchdog by writing the watchdog reload register.

All configuration goes through a word-wide register port. Writes take effect on the next clock edge, and reads are combinational.

Top module: `tick_timer_unit`

## Requirements
- R1: The prescaler count sits at address 0 and its 10-bit reload at address 1. The count decrements by one each clock. In a cycle where the count is zero, the block emits a tick and the count takes the reload value, so a tick occurs every (reload + 1) cycles. A write to address 0 sets the count directly.
- R2: A timer count holds its value in every cycle without a tick.
- R3: In periodic mode (control bit 1 = 1), an enabled timer that sees a tick while its count is zero reloads from its reload register and raises its interrupt. The interval between interrupts is therefore (prescaler reload + 1) × (timer reload + 1) clocks.
- R4: In one-shot mode (control bit 1 = 0), the underflow raises one interrupt, clears the enable bit and leaves the count at zero. No further interrupts follow.
- R5: Each interrupt is a single clock wide and appears only in the cycle after a tick.
- R6: The register map for timer n is: count at 2+3n, reload at 3+3n, control at 4+3n. In the control register, bit 0 is enable, bit 1 is periodic and bit 2 is load. Writing load = 1 copies the reload value into the count. The load bit always reads back as 0.
- R7: The two timers are independent. Running timer 1 produces no interrupt on timer 0.
- R8: The watchdog count sits at address 8 (read only) and decrements on each tick until it reaches zero. While the count is zero, the output `wdog_n` is low, and it stays low.
- R9: A write of a nonzero value to the watchdog reload register (address 9) loads that value into the watchdog count and drives `wdog_n` high from the next cycle.
- R10: After reset, the timers are disabled with zero count and zero reload, the prescaler reload is zero, both interrupts are low, the watchdog reload holds all ones and `wdog_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tmr_irq | output | 2 | One-clock underflow pulse per timer |
| wdog_n | output | 1 | Active-low watchdog timeout |

## Verification
The hardest condition to observe from the ports is that a counter stays frozen between ticks. With a small prescaler reload the gap between ticks is only a cycle or two, too short to read the count inside it. The stimulus sets the prescaler reload and count near 1000 and then loads a timer. It reads the count a hundred cycles later and expects the value unchanged. Interrupt spacing is measured between consecutive pulses for a table of prescaler and timer reload pairs. This exposes any off-by-one error in either counter.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    // register layout: prescaler pair, then per-timer triples, then watchdog pair
    localparam int unsigned REG_PRE_CNT = 0;
    localparam int unsigned REG_PRE_RLD = 1;
    localparam int unsigned TMR_BASE    = 2;
    localparam int unsigned TMR_STRIDE  = 3;
    localparam int unsigned OFF_CNT     = 0;
    localparam int unsigned OFF_RLD     = 1;
    localparam int unsigned OFF_CTL     = 2;

    // control field positions
    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_PER  = 1;
    localparam int unsigned CTL_LOAD = 2;

    function automatic int unsigned tmr_addr(int unsigned idx, int unsigned off);
        return TMR_BASE + TMR_STRIDE * idx + off;
    endfunction

    function automatic int unsigned wd_addr(int unsigned n_tmr, int unsigned off);
        return TMR_BASE + TMR_STRIDE * n_tmr + off;
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] cnt,
    output logic [PRE_W-1:0] rld,
    output logic             tick
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] rld;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_rld) begin
            st_d.rld = wdata;
        end
        if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = st_q.rld;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign rld  = st_q.rld;
    assign tick = (st_q.cnt == '0);
endmodule

// File: rtl/tick_gp_timer.sv
module tick_gp_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ctl_en,
    input  logic             ctl_per,
    input  logic             ctl_load,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rld,
    output logic             en,
    output logic             per,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             en;
        logic             per;
        logic             irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    underflow;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        underflow = tick && st_q.en && (st_q.cnt == '0);

        if (underflow) begin
            st_d.irq = 1'b1;
            if (st_q.per) begin
                st_d.cnt = st_q.rld;
            end else begin
                st_d.en = 1'b0;
            end
        end else if (tick && st_q.en) begin
            st_d.cnt = st_q.cnt - ONE;
        end

        // register writes take priority over counting
        if (wr_rld) begin
            st_d.rld = wdata;
        end
        if (wr_cnt) begin
            st_d.cnt = wdata;
        end
        if (wr_ctl) begin
            st_d.en  = ctl_en;
            st_d.per = ctl_per;
            if (ctl_load) begin
                st_d.cnt = st_q.rld;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign rld = st_q.rld;
    assign en  = st_q.en;
    assign per = st_q.per;
    assign irq = st_q.irq;
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
    parameter int               CNT_W  = 24,
    parameter logic [CNT_W-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_rld,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rld,
    output logic             expired_n
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             out_n;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_rld) begin
            st_d.rld = wdata;
            st_d.cnt = wdata;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
        st_d.out_n = (st_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= RST_VAL;
            st_q.rld   <= RST_VAL;
            st_q.out_n <= (RST_VAL != '0);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt       = st_q.cnt;
    assign rld       = st_q.rld;
    assign expired_n = st_q.out_n;
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import tick_timer_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter int               PRE_W  = 10,
    parameter int               CNT_W  = 24,
    parameter int               N_TMR  = 2,
    parameter logic [CNT_W-1:0] WD_RST = '1,
    localparam int              N_REGS = TMR_BASE + TMR_STRIDE * N_TMR + 2,
    localparam int              ADDR_W = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_TMR-1:0]  tmr_irq,
    output logic              wdog_n
);
    localparam logic [ADDR_W-1:0] A_PRE_CNT = ADDR_W'(REG_PRE_CNT);
    localparam logic [ADDR_W-1:0] A_PRE_RLD = ADDR_W'(REG_PRE_RLD);
    localparam logic [ADDR_W-1:0] A_WD_CNT  = ADDR_W'(wd_addr(N_TMR, 0));
    localparam logic [ADDR_W-1:0] A_WD_RLD  = ADDR_W'(wd_addr(N_TMR, 1));

    logic                        presc_tick;
    logic [PRE_W-1:0]            pre_cnt, pre_rld;
    logic [N_TMR-1:0][CNT_W-1:0] tmr_cnt, tmr_rld;
    logic [N_TMR-1:0]            tmr_en, tmr_per;
    logic [CNT_W-1:0]            wd_cnt, wd_rld;

    logic             wr_pre_cnt, wr_pre_rld, wr_wd_rld;
    logic [N_TMR-1:0] wr_t_cnt, wr_t_rld, wr_t_ctl;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];

    // write decode
    always_comb begin
        wr_pre_cnt = reg_we && (reg_addr == A_PRE_CNT);
        wr_pre_rld = reg_we && (reg_addr == A_PRE_RLD);
        wr_wd_rld  = reg_we && (reg_addr == A_WD_RLD);
        for (int i = 0; i < N_TMR; i++) begin
            wr_t_cnt[i] = reg_we && (reg_addr == ADDR_W'(tmr_addr(i, OFF_CNT)));
            wr_t_rld[i] = reg_we && (reg_addr == ADDR_W'(tmr_addr(i, OFF_RLD)));
            wr_t_ctl[i] = reg_we && (reg_addr == ADDR_W'(tmr_addr(i, OFF_CTL)));
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_PRE_CNT) reg_rdata = DATA_W'(pre_cnt);
        if (reg_addr == A_PRE_RLD) reg_rdata = DATA_W'(pre_rld);
        if (reg_addr == A_WD_CNT)  reg_rdata = DATA_W'(wd_cnt);
        if (reg_addr == A_WD_RLD)  reg_rdata = DATA_W'(wd_rld);
        for (int i = 0; i < N_TMR; i++) begin
            if (reg_addr == ADDR_W'(tmr_addr(i, OFF_CNT))) reg_rdata = DATA_W'(tmr_cnt[i]);
            if (reg_addr == ADDR_W'(tmr_addr(i, OFF_RLD))) reg_rdata = DATA_W'(tmr_rld[i]);
            if (reg_addr == ADDR_W'(tmr_addr(i, OFF_CTL))) begin
                reg_rdata[CTL_EN]  = tmr_en[i];
                reg_rdata[CTL_PER] = tmr_per[i];
            end
        end
    end

    tick_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cnt (wr_pre_cnt),
        .wr_rld (wr_pre_rld),
        .wdata  (reg_wdata[PRE_W-1:0]),
        .cnt    (pre_cnt),
        .rld    (pre_rld),
        .tick   (presc_tick)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        tick_gp_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (presc_tick),
            .wr_cnt   (wr_t_cnt[g]),
            .wr_rld   (wr_t_rld[g]),
            .wr_ctl   (wr_t_ctl[g]),
            .wdata    (reg_wdata[CNT_W-1:0]),
            .ctl_en   (reg_wdata[CTL_EN]),
            .ctl_per  (reg_wdata[CTL_PER]),
            .ctl_load (reg_wdata[CTL_LOAD]),
            .cnt      (tmr_cnt[g]),
            .rld      (tmr_rld[g]),
            .en       (tmr_en[g]),
            .per      (tmr_per[g]),
            .irq      (tmr_irq[g])
        );
    end

    tick_watchdog #(.CNT_W(CNT_W), .RST_VAL(WD_RST)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (presc_tick),
        .wr_rld    (wr_wd_rld),
        .wdata     (reg_wdata[CNT_W-1:0]),
        .cnt       (wd_cnt),
        .rld       (wd_rld),
        .expired_n (wdog_n)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int N_TMR  = 2,
    parameter int ADDR_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [CNT_W-1:0]            wdata,
    input logic                        tick,
    input logic [N_TMR-1:0][CNT_W-1:0] tmr_cnt,
    input logic [N_TMR-1:0][CNT_W-1:0] tmr_rld,
    input logic [N_TMR-1:0]            tmr_en,
    input logic [N_TMR-1:0]            tmr_per,
    input logic [N_TMR-1:0]            tmr_irq,
    input logic [CNT_W-1:0]            wd_cnt,
    input logic                        wdog_n
);
    localparam logic [ADDR_W-1:0] A_WD_RLD = ADDR_W'(wd_addr(N_TMR, 1));

    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
        a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !reg_we) |=> $stable(tmr_cnt[i]));

        a_r3_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && tmr_en[i] && tmr_per[i] && tmr_cnt[i] == '0 && !reg_we)
            |=> (tmr_irq[i] && tmr_cnt[i] == tmr_rld[i]));

        a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && tmr_en[i] && !tmr_per[i] && tmr_cnt[i] == '0 && !reg_we)
            |=> (tmr_irq[i] && !tmr_en[i] && tmr_cnt[i] == '0));

        a_r5_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_irq[i] |-> $past(tick));
    end

    a_r8_wdog_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_cnt == '0 && !reg_we) |=> !wdog_n);

    a_r9_wdog_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_WD_RLD && wdata != '0) |=> wdog_n);
endmodule

bind tick_timer_unit tick_timer_chk #(
    .CNT_W  (CNT_W),
    .N_TMR  (N_TMR),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wdata    (reg_wdata[CNT_W-1:0]),
    .tick     (presc_tick),
    .tmr_cnt  (tmr_cnt),
    .tmr_rld  (tmr_rld),
    .tmr_en   (tmr_en),
    .tmr_per  (tmr_per),
    .tmr_irq  (tmr_irq),
    .wd_cnt   (wd_cnt),
    .wdog_n   (wdog_n)
);

// File: tb/tick_timer_unit_bench.sv
module tick_timer_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // prescaler reload, timer reload, expected clocks between interrupts
    localparam int VECS [NVEC][3] = '{
        '{0, 4, 5}, '{3, 2, 12}, '{1, 7, 16}, '{9, 1, 20}, '{2, 0, 3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  tmr_irq;
    logic        wdog_n;

    int checks = 0;
    int errors = 0;
    int irq0_cnt = 0;
    bit finished = 1'b0;

    tick_timer_unit u_tick_timer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tmr_irq   (tmr_irq),
        .wdog_n    (wdog_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (rst_n && tmr_irq[0]) irq0_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq(input int idx, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tmr_irq[idx] && n < 5000);
        if (!tmr_irq[idx]) n = -1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check("R10 wdog_n after reset", 32'(wdog_n), 32'd1);
        check("R10 irq after reset", 32'(tmr_irq), 32'd0);
        rd(4'd1, d); check("R10 prescaler reload", d, 32'd0);
        rd(4'd3, d); check("R10 timer0 reload", d, 32'd0);
        rd(4'd4, d); check("R10 timer0 control", d, 32'd0);
        rd(4'd7, d); check("R10 timer1 control", d, 32'd0);
        rd(4'd9, d); check("R10 watchdog reload", d, 32'hFFFFFF);

        // R3 / R5 periodic interval table on timer 0
        for (int v = 0; v < NVEC; v++) begin
            wr(4'd4, 32'd0);
            wr(4'd1, 32'(VECS[v][0]));
            wr(4'd0, 32'd0);
            wr(4'd3, 32'(VECS[v][1]));
            wr(4'd4, 32'd7);
            wait_irq(0, n);
            wait_irq(0, n);
            check($sformatf("R3 interval vec%0d", v), 32'(n), 32'(VECS[v][2]));
            @(negedge clk);
            check($sformatf("R5 pulse width vec%0d", v), 32'(tmr_irq[0]), 32'd0);
        end
        wr(4'd4, 32'd0);

        // R7 timer 1 alone
        wr(4'd1, 32'd1);
        wr(4'd0, 32'd0);
        wr(4'd6, 32'd3);
        wr(4'd7, 32'd7);
        base = irq0_cnt;
        wait_irq(1, n);
        wait_irq(1, n);
        check("R7 timer1 interval", 32'(n), 32'd8);
        check("R7 no timer0 irq", 32'(irq0_cnt - base), 32'd0);
        wr(4'd7, 32'd0);

        // R4 one-shot
        wr(4'd3, 32'd3);
        wr(4'd4, 32'd5);
        wait_irq(0, n);
        check("R4 one-shot fired", 32'(n > 0), 32'd1);
        rd(4'd4, d); check("R4 enable cleared", d, 32'd0);
        rd(4'd2, d); check("R4 count left at zero", d, 32'd0);
        base = irq0_cnt;
        repeat (200) @(negedge clk);
        check("R4 no further irq", 32'(irq0_cnt - base), 32'd0);

        // R6 control fields
        wr(4'd2, 32'd9);
        rd(4'd2, d); check("R6 count write", d, 32'd9);
        wr(4'd3, 32'd6);
        wr(4'd4, 32'd4);
        rd(4'd2, d); check("R6 load copies reload", d, 32'd6);
        rd(4'd4, d); check("R6 load reads zero", d, 32'd0);
        wr(4'd4, 32'd2);
        rd(4'd4, d); check("R6 periodic bit readback", d, 32'd2);

        // R2 hold between ticks with a long prescaler period
        wr(4'd1, 32'd1000);
        wr(4'd0, 32'd1000);
        wr(4'd3, 32'd50);
        wr(4'd4, 32'd7);
        repeat (100) @(negedge clk);
        rd(4'd2, d); check("R2 count held between ticks", d, 32'd50);
        wr(4'd4, 32'd0);

        // R1 prescaler count
        wr(4'd0, 32'd700);
        rd(4'd0, d); check("R1 prescaler count write", d, 32'd700);
        repeat (5) @(negedge clk);
        rd(4'd0, d); check("R1 prescaler decrement", d, 32'd695);
        wr(4'd1, 32'h155);
        rd(4'd1, d); check("R1 prescaler reload readback", d, 32'h155);

        // R8 / R9 watchdog with a tick every cycle
        wr(4'd1, 32'd0);
        wr(4'd0, 32'd0);
        wr(4'd9, 32'd5);
        check("R9 release after restart", 32'(wdog_n), 32'd1);
        rd(4'd8, d); check("R9 count restarted", d, 32'd5);
        repeat (2) @(negedge clk);
        rd(4'd8, d); check("R8 watchdog decrement", d, 32'd3);
        check("R8 not yet expired", 32'(wdog_n), 32'd1);
        repeat (6) @(negedge clk);
        check("R8 expired low", 32'(wdog_n), 32'd0);
        rd(4'd8, d); check("R8 count at zero", d, 32'd0);
        repeat (20) @(negedge clk);
        check("R8 stays low", 32'(wdog_n), 32'd0);
        wr(4'd9, 32'd40);
        check("R9 release second restart", 32'(wdog_n), 32'd1);
        rd(4'd9, d); check("R9 reload readback", d, 32'd40);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule